// File: doc/BRIEF.md
# Flash erase sequencer

This block carries out one complete erase of an external serial flash on a single-lane SPI link (mode 0). A one-cycle start pulse comes with an address, a size code and an addressing-mode flag. The block sends a write-enable command in a chip-select frame of its own. It then sends the erase command in a second frame. Next it reads the flash status register again and again, in separate frames, until the flash reports that its internal operation has finished. At that point it emits a single-cycle ready event.

The last status byte it read stays available on a status word, together with a ready flag. An integer divider input sets the serial clock rate. A parameter sets the minimum chip-select high time between frames.

Top module: `flash_erase_seq`

## Requirements
- R1: Every accepted operation begins with a frame that holds only the byte 0x06, bounded by chip select on both sides.
- R2: The second frame starts with the erase opcode chosen by `size_i`: 0 gives 0x20 (4 KB), 1 gives 0xD8 (64 KB), 2 gives 0xC7 (whole chip).
- R3: For sizes 0 and 1, the erase opcode is followed by the address, most significant byte first. There are 3 bytes (bits 23..0) when `addr4b_i` is 0 and 4 bytes (bits 31..0) when it is 1. A chip erase frame carries the opcode alone.
- R4: Address bits 1..0 are always sent as zero, so a misaligned address is forced down to a 4-byte boundary.
- R5: After the erase frame, the block sends two-byte frames of 0x05 followed by a dummy byte. It captures the byte read back in each. It repeats these frames, releasing chip select between them, while bit 0 of the captured byte is 1, and stops after the first frame that returns bit 0 equal to 0.
- R6: Between any two frames, chip select stays high for at least GAP_CYC clock cycles, and no serial clock toggles while it is high.
- R7: `ready_evt_o` pulses high for exactly one cycle, once per accepted operation, after the last status frame and its gap.
- R8: `status_o[7:0]` holds the last status byte read. `status_o[8]` is 1 when idle and 0 while an operation is running.
- R9: A start pulse is ignored while an operation runs, and also when `size_i` is 3. An ignored start causes no frame and no event.
- R10: The serial clock idles low. Each of its high and low phases lasts `clk_div_i`+1 clock cycles. Data changes on the falling edge and is sampled on the rising edge.
- R11: After reset, chip select is high, the serial clock and data are low, `status_o` is 0x100, and no event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an erase |
| addr_i | input | 32 | Erase start address |
| size_i | input | 2 | Size code: 0 = 4 KB, 1 = 64 KB, 2 = chip, 3 = reserved |
| addr4b_i | input | 1 | 1 selects a 4-byte address phase, 0 a 3-byte phase |
| clk_div_i | input | DIV_W | Serial clock half-period minus one, in clock cycles |
| spi_sck_o | output | 1 | Serial clock to the flash |
| spi_cs_no | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| ready_evt_o | output | 1 | One-cycle completion event |
| status_o | output | 9 | Bit 8 ready flag, bits 7..0 last flash status byte |

## Verification
The bench drives the sequencer against a behavioural flash that records every frame and answers status reads with a programmable number of busy replies. Each size code is run in turn. A 4 KB erase in 3-byte mode with a misaligned address exposes the byte order and the alignment masking. A 64 KB erase in 4-byte mode with no busy replies tells the address lengths apart and shows that polling stops on the first idle status. A chip erase with several busy replies shows that no address is sent and that polling repeats in separate frames. Further runs cover the reserved size code, a second start during an operation, and two divider settings, and check that nothing changes other than the serial clock timing.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int ADDR_W = 32;

  localparam logic [7:0] OP_WR_EN    = 8'h06;
  localparam logic [7:0] OP_RD_STAT  = 8'h05;
  localparam logic [7:0] OP_ERASE_4K = 8'h20;
  localparam logic [7:0] OP_ERASE_64K = 8'h D8;
  localparam logic [7:0] OP_ERASE_ALL = 8'hC7;

  typedef enum logic [1:0] {SZ_4K = 2'd0, SZ_64K = 2'd1, SZ_CHIP = 2'd2, SZ_RSVD = 2'd3} erase_sz_e;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} seq_st_e;
  typedef enum logic [1:0] {FR_WREN, FR_ERASE, FR_POLL} frame_e;

  function automatic logic [7:0] erase_op(erase_sz_e sz);
    case (sz)
      SZ_4K:   return OP_ERASE_4K;
      SZ_64K:  return OP_ERASE_64K;
      default: return OP_ERASE_ALL;
    endcase
  endfunction
endpackage

// File: rtl/flash_sck_tick.sv
module flash_sck_tick #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == div_i);
endmodule

// File: rtl/flash_byte_shift.sv
module flash_byte_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              go_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              active_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              active_q, sck_q, done_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        sck_q    <= 1'b0;
        bit_q    <= '0;
        tx_q     <= tx_i;
      end else if (active_q && tick_i) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[BYTE_W-2:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sck_o    = sck_q;
  assign mosi_o   = active_q & tx_q[BYTE_W-1];
  assign active_o = active_q;
  assign done_o   = done_q;
  assign rx_o     = rx_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sck_q); // R10
endmodule

// File: rtl/flash_erase_fsm.sv
module flash_erase_fsm
  import flash_erase_pkg::*;
#(
  parameter int GAP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              addr4b_i,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  output logic              sh_go_o,
  output logic [7:0]        tx_byte_o,
  output logic              cs_no,
  output logic              ready_evt_o,
  output logic              busy_o,
  output logic [7:0]        stat_byte_o
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_END = GAP_W'(GAP_CYC - 1);

  seq_st_e           st_q;
  frame_e            frame_q;
  erase_sz_e         sz_q;
  logic [2:0]        idx_q;
  logic [GAP_W-1:0]  gap_q;
  logic [ADDR_W-1:0] addr_q;
  logic              a4_q, go_q, cs_n_q, evt_q, wip_q;
  logic [7:0]        stat_q;

  logic [2:0] last_idx, addr_bytes, shift_amt;
  logic       ok_start;

  assign addr_bytes = a4_q ? 3'd4 : 3'd3;
  assign shift_amt  = addr_bytes - idx_q;
  assign ok_start   = start_i && (erase_sz_e'(size_i) != SZ_RSVD);

  always_comb begin
    case (frame_q)
      FR_WREN:  last_idx = 3'd0;
      FR_ERASE: last_idx = (sz_q == SZ_CHIP) ? 3'd0 : addr_bytes;
      default:  last_idx = 3'd1;
    endcase
  end

  always_comb begin
    case (frame_q)
      FR_WREN:  tx_byte_o = OP_WR_EN;
      FR_ERASE: tx_byte_o = (idx_q == 3'd0) ? erase_op(sz_q)
                                            : 8'(addr_q >> {shift_amt, 3'b000});
      default:  tx_byte_o = (idx_q == 3'd0) ? OP_RD_STAT : 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      frame_q <= FR_WREN;
      sz_q    <= SZ_4K;
      idx_q   <= '0;
      gap_q   <= '0;
      addr_q  <= '0;
      a4_q    <= 1'b0;
      go_q    <= 1'b0;
      cs_n_q  <= 1'b1;
      evt_q   <= 1'b0;
      wip_q   <= 1'b0;
      stat_q  <= '0;
    end else begin
      go_q  <= 1'b0;
      evt_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (ok_start) begin
          addr_q  <= addr_i & ~ADDR_W'(3);
          sz_q    <= erase_sz_e'(size_i);
          a4_q    <= addr4b_i;
          frame_q <= FR_WREN;
          idx_q   <= '0;
          cs_n_q  <= 1'b0;
          go_q    <= 1'b1;
          st_q    <= ST_XFER;
        end
        ST_XFER: if (sh_done_i) begin
          if (frame_q == FR_POLL && idx_q == 3'd1) begin
            stat_q <= sh_rx_i;
            wip_q  <= sh_rx_i[0];
          end
          if (idx_q == last_idx) begin
            cs_n_q <= 1'b1;
            gap_q  <= '0;
            st_q   <= ST_GAP;
          end else begin
            idx_q <= idx_q + 1'b1;
            go_q  <= 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_END) begin
            if (frame_q == FR_POLL && !wip_q) begin
              evt_q <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              frame_q <= (frame_q == FR_WREN) ? FR_ERASE : FR_POLL;
              idx_q   <= '0;
              cs_n_q  <= 1'b0;
              go_q    <= 1'b1;
              st_q    <= ST_XFER;
            end
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sh_go_o     = go_q;
  assign cs_no       = cs_n_q;
  assign ready_evt_o = evt_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign stat_byte_o = stat_q;

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q); // R7
  AST_EVT_WIP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> !stat_q[0]); // R5
  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> cs_n_q); // R6
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_XFER && start_i && !sh_done_i) |=> (st_q == ST_XFER)); // R9
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int GAP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       addr_i,
  input  logic [1:0]        size_i,
  input  logic              addr4b_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  output logic              spi_sck_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic              ready_evt_o,
  output logic [8:0]        status_o
);
  logic       tick, sh_go, sh_active, sh_done, busy;
  logic [7:0] sh_rx, tx_byte, stat_byte;

  flash_sck_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sh_active),
    .div_i  (clk_div_i),
    .tick_o (tick)
  );

  flash_byte_shift #(.BYTE_W(8)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .go_i     (sh_go),
    .tx_i     (tx_byte),
    .miso_i   (spi_miso_i),
    .sck_o    (spi_sck_o),
    .mosi_o   (spi_mosi_o),
    .active_o (sh_active),
    .done_o   (sh_done),
    .rx_o     (sh_rx)
  );

  flash_erase_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .size_i      (size_i),
    .addr4b_i    (addr4b_i),
    .sh_done_i   (sh_done),
    .sh_rx_i     (sh_rx),
    .sh_go_o     (sh_go),
    .tx_byte_o   (tx_byte),
    .cs_no       (spi_cs_no),
    .ready_evt_o (ready_evt_o),
    .busy_o      (busy),
    .stat_byte_o (stat_byte)
  );

  assign status_o = {~busy, stat_byte};

  AST_CS_HIGH_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !sh_active); // R6
  AST_GO_ONLY_IDLE_SHIFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_go |-> !sh_active); // R1
endmodule

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;
  localparam int DIV_W = 4;
  localparam int GAP   = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, addr4b_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0] size_i = '0;
  logic [DIV_W-1:0] clk_div_i = '0;
  logic spi_sck_o, spi_cs_no, spi_mosi_o, spi_miso_i, ready_evt_o;
  logic [8:0] status_o;

  always #10 clk_i = ~clk_i;

  flash_erase_seq #(.DIV_W(DIV_W), .GAP_CYC(GAP)) dut_i (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  // flash model
  int bit_cnt = 0, nframes = 0, busy_left = 0;
  logic [7:0] cur = '0, final_stat = '0;
  logic [7:0] fbytes [0:15][0:7];
  int flen [0:15];
  logic [7:0] resp;
  assign resp = (busy_left > 0) ? 8'h03 : final_stat;
  assign spi_miso_i = (!spi_cs_no && bit_cnt >= 8 && bit_cnt < 16 && fbytes[nframes][0] == 8'h05)
                      ? resp[15 - bit_cnt] : 1'b0;

  always @(negedge spi_cs_no) bit_cnt = 0;
  always @(posedge spi_sck_o) if (!spi_cs_no) begin
    cur = {cur[6:0], spi_mosi_o};
    bit_cnt++;
    if (bit_cnt % 8 == 0 && bit_cnt <= 64) fbytes[nframes][bit_cnt/8 - 1] = cur;
  end
  always @(posedge spi_cs_no) if (rst_ni) begin
    flen[nframes] = bit_cnt / 8;
    if (fbytes[nframes][0] == 8'h05 && busy_left > 0) busy_left--;
    if (nframes < 15) nframes++;
  end

  // monitors
  int evt_cnt = 0, gap_run = 0, min_gap = 1000000, hi_run = 0, hi_min = 1000000, hi_max = 0;
  always @(posedge clk_i) begin
    if (ready_evt_o) evt_cnt++;
    if (spi_cs_no) gap_run++;
    else begin
      if (gap_run > 0 && gap_run < min_gap) min_gap = gap_run;
      gap_run = 0;
    end
    if (spi_sck_o) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_model(input int polls, input logic [7:0] fin);
    nframes = 0; busy_left = polls; final_stat = fin; evt_cnt = 0;
    min_gap = 1000000; hi_min = 1000000; hi_max = 0;
    for (int f = 0; f < 16; f++) begin
      flen[f] = 0;
      for (int b = 0; b < 8; b++) fbytes[f][b] = 8'h00;
    end
  endtask

  task automatic pulse_start(input logic [1:0] sz, input logic [31:0] a, input logic a4);
    @(negedge clk_i);
    start_i = 1'b1; size_i = sz; addr_i = a; addr4b_i = a4;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run_erase(input logic [1:0] sz, input logic [31:0] a, input logic a4,
                           input int polls, input logic [7:0] fin, input int div, input int dup_at);
    logic [7:0] exp_op;
    logic [31:0] al;
    int nab, waited;
    clk_div_i = DIV_W'(div);
    clear_model(polls, fin);
    pulse_start(sz, a, a4);
    repeat (3) @(negedge clk_i);
    check("R8 busy flag", status_o[8], 1'b0);
    waited = 0;
    while (evt_cnt == 0 && waited < 20000) begin
      @(negedge clk_i);
      waited++;
      if (waited == dup_at) pulse_start(2'd2, 32'hFFFF_FFFF, 1'b1);
    end
    repeat (40) @(negedge clk_i);
    exp_op = (sz == 2'd0) ? 8'h20 : (sz == 2'd1) ? 8'hD8 : 8'hC7;
    nab = (sz == 2'd2) ? 0 : (a4 ? 4 : 3);
    al = a & ~32'h3;
    check("R7 event count", evt_cnt, 1);
    check("R5 frame count", nframes, 3 + polls);
    check("R1 wren length", flen[0], 1);
    check("R1 wren byte", fbytes[0][0], 8'h06);
    check("R2 erase opcode", fbytes[1][0], exp_op);
    check("R3 erase length", flen[1], 1 + nab);
    for (int k = 1; k <= nab; k++)
      check("R3 R4 address byte", fbytes[1][k], 8'(al >> (8 * (nab - k))));
    for (int f = 2; f < 3 + polls; f++) begin
      check("R5 poll length", flen[f], 2);
      check("R5 poll opcode", fbytes[f][0], 8'h05);
    end
    check("R8 final status", status_o, {1'b1, fin});
    check("R6 gap", (min_gap >= GAP), 1);
    check("R10 sck high min", hi_min, div + 1);
    check("R10 sck high max", hi_max, div + 1);
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    check("R11 cs", spi_cs_no, 1'b1);
    check("R11 sck", spi_sck_o, 1'b0);
    check("R11 mosi", spi_mosi_o, 1'b0);
    check("R11 status", status_o, 9'h100);
    check("R11 event", ready_evt_o, 1'b0);
  endtask

  task automatic test_reserved();
    clear_model(0, 8'h00);
    pulse_start(2'd3, 32'h0000_1000, 1'b0);
    repeat (200) @(negedge clk_i);
    check("R9 reserved no frame", nframes, 0);
    check("R9 reserved no event", evt_cnt, 0);
    check("R9 reserved cs", spi_cs_no, 1'b1);
    check("R9 reserved ready", status_o[8], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    run_erase(2'd0, 32'h0012_3456, 1'b0, 2, 8'hA2, 0, 0);  // 4 KB, 3-byte, misaligned
    run_erase(2'd1, 32'hA1B2_C3D7, 1'b1, 0, 8'h5C, 3, 0);  // 64 KB, 4-byte
    run_erase(2'd2, 32'h1234_5678, 1'b1, 3, 8'h40, 1, 0);  // chip erase
    test_reserved();
    run_erase(2'd0, 32'h00FF_0003, 1'b1, 1, 8'h00, 2, 30); // R9 second start mid-op
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule